// File: doc/BRIEF.md
# Programming Link Entry/Exit Sequencer

This controller brings a target device's two-wire programming link up and down. It never moves a byte itself. It sets the output enables and driven levels of three target pins: clock, data and a dedicated reset. It tells an attached serial PHY when to let its clock run, when to emit a break character and when to turn its data path to receive. It reports a link-ready flag and a two-bit phase code. Byte traffic and command handling sit outside the block.

The block supports two target styles. The style is captured when the enable request is accepted.

- **Data-override style** (mode 0): the data pin doubles as a reset override. The link is raised by holding data high before any clock edge. It is torn down by parking the clock pin high for a long interval, which restarts the target, and then floating both pins.
- **Dedicated-reset style** (mode 1): a separate active-low reset pin is pulled low first. On teardown the clock and data pins are floated one cycle before the reset pin is let go.

In both styles the PHY then sends a fixed number of breaks, two by default. A break is a frame's worth of idle bits, and together the two give the target at least sixteen idle bits. Only after the last break does the block declare the link up.

The guard intervals are parameters in nanoseconds and microseconds. They are turned into cycle counts from the system clock frequency at elaboration. With a 250 MHz clock the 90 ns guard becomes 23 cycles (SETUP_CYC) and the 1 ms restart hold becomes 250000 cycles (HOLD_CYC).

Top module: `prog_link_seq`

## Requirements
- R1: In mode 0 (`mode_i`=0 when enable is accepted), for exactly SETUP_CYC cycles after the enable, data is driven high, clock is driven low with `phy_clk_run_o`=0, and the reset pin is released.
- R2: In mode 1, for exactly SETUP_CYC cycles after the enable, the reset pin is driven low (`rst_oe_o`=1, `rst_out_o`=0) and the clock and data pins are both released.
- R3: After the guard interval:
  - the clock runs and data is driven high; in mode 1 reset stays driven low;
  - `phy_brk_start_o` pulses for one cycle;
  - each following break is requested in the cycle after a `phy_brk_done_i` pulse, two breaks in all.
- R4: `link_ready_o` rises in the cycle after the last break completes and stays high until a disable is accepted.
- R5: A disable accepted while ready:
  - asserts `phy_rx_sel_o` and releases data while the clock keeps running;
  - the block stays there until `phy_tx_idle_i` is high;
  - `phy_rx_sel_o` then stays high until the block returns to idle.
- R6: In mode 0, once the PHY is idle, clock is driven high with the clock stopped for exactly HOLD_CYC cycles, after which all pins are released and the block is idle.
- R7: In mode 1, once the PHY is idle, there is one cycle with clock and data released and reset still driven low, and then reset is released.
- R8: `status_o` encodes the phase: 0 idle, 1 entering (guard or breaks), 2 active, 3 exiting.
- R9: After reset all output enables, driven levels and PHY controls are 0 and `status_o` is 0.
- R10: An enable request outside the idle phase, and a disable request outside the active phase, have no effect on any output.
- R11: The mode is sampled only when an enable is accepted; changing `mode_i` later has no effect until the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Target style: 0 data-override, 1 dedicated reset |
| enable_req_i | input | 1 | Request to bring the link up (honoured only when idle) |
| disable_req_i | input | 1 | Request to take the link down (honoured only when active) |
| phy_brk_start_o | output | 1 | One-cycle pulse asking the PHY to send one break |
| phy_brk_done_i | input | 1 | One-cycle pulse from the PHY when a break has finished |
| phy_rx_sel_o | output | 1 | Asks the PHY to finish transmitting and switch to receive |
| phy_tx_idle_i | input | 1 | PHY has no transmission pending |
| phy_clk_run_o | output | 1 | Lets the PHY toggle the clock pin |
| clk_oe_o | output | 1 | Clock pin output enable |
| clk_out_o | output | 1 | Clock pin level while it is held static |
| dat_oe_o | output | 1 | Data pin output enable |
| dat_out_o | output | 1 | Data pin idle level |
| rst_oe_o | output | 1 | Reset pin output enable |
| rst_out_o | output | 1 | Reset pin level |
| link_ready_o | output | 1 | Link is up and usable |
| status_o | output | 2 | Phase code (see R8) |

## Verification
Every output is registered state, so the bench expects each effect in the cycle that follows the edge that sampled the causing input. For example, an enable sampled at edge E changes the pins at E, and a break-done pulse sampled at E makes the next break request or the ready flag visible right after E. The bench drives inputs and samples outputs on the falling edge, and its behavioural model advances on the rising edge using the same input values as the design. The two are therefore compared one half cycle after each change, and a guard or hold interval that is one cycle too long or too short shows up as a mismatch in a single cycle. A stand-in PHY answers each break request six cycles later, and the drain phase is held open for several cycles, so that the waits on the PHY are actually exercised.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;

   typedef enum logic [2:0] {
      PL_IDLE     = 3'd0,
      PL_SETUP    = 3'd1,
      PL_BRK_REQ  = 3'd2,
      PL_BRK_WAIT = 3'd3,
      PL_ACTIVE   = 3'd4,
      PL_DRAIN    = 3'd5,
      PL_HOLD     = 3'd6,
      PL_REL      = 3'd7
   } pl_state_e;

   typedef enum logic {
      PL_MODE_DATOVR = 1'b0,
      PL_MODE_RSTPIN = 1'b1
   } pl_mode_e;

   typedef enum logic [1:0] {
      PL_ST_IDLE   = 2'd0,
      PL_ST_ENTER  = 2'd1,
      PL_ST_ACTIVE = 2'd2,
      PL_ST_EXIT   = 2'd3
   } pl_status_e;

   typedef struct packed {
      logic clk_oe;
      logic clk_lvl;
      logic clk_run;
      logic dat_oe;
      logic dat_lvl;
      logic rst_oe;
      logic rst_assert;
      logic rx_sel;
   } pl_pins_t;

   // Round a nanosecond interval up to whole clock cycles.
   function automatic longint pl_ns_to_cyc(longint hz, longint ns);
      return (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

   // Convert a microsecond interval to clock cycles.
   function automatic longint pl_us_to_cyc(longint hz, longint us);
      return (us * hz) / 64'd1_000_000;
   endfunction

endpackage

// File: rtl/plseq_timer.sv
module plseq_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   // A freshly loaded nonzero value must not read as expired on the next cycle.
   AST_TMR_LOAD_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && load_val_i != '0) |=> !zero_o);   // R1

endmodule

// File: rtl/plseq_brk_cnt.sv
module plseq_brk_cnt #(
   parameter int unsigned BREAKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   localparam int unsigned BW = (BREAKS < 2) ? 1 : $clog2(BREAKS + 1);

   logic [BW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last_o = (cnt_q == BW'(BREAKS - 1));

   AST_BRK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= BW'(BREAKS));   // R3

endmodule

// File: rtl/plseq_ctrl.sv
module plseq_ctrl
   import prog_link_pkg::*;
#(
   parameter int unsigned CW        = 8,
   parameter int unsigned SETUP_CYC = 23,
   parameter int unsigned HOLD_CYC  = 250
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_i,
   input  logic          enable_req_i,
   input  logic          disable_req_i,
   input  logic          tmr_zero_i,
   input  logic          brk_done_i,
   input  logic          brk_last_i,
   input  logic          tx_idle_i,
   output pl_state_e     state_o,
   output pl_mode_e      mode_o,
   output logic          tmr_load_o,
   output logic [CW-1:0] tmr_val_o,
   output logic          brk_clr_o,
   output logic          brk_inc_o
);

   pl_state_e st_q, st_d;
   pl_mode_e  mode_q;
   logic      mode_ld;

   always_comb begin
      st_d       = st_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      brk_clr_o  = 1'b0;
      brk_inc_o  = 1'b0;
      mode_ld    = 1'b0;
      unique case (st_q)
         PL_IDLE: begin
            if (enable_req_i) begin
               st_d       = PL_SETUP;
               tmr_load_o = 1'b1;
               tmr_val_o  = CW'(SETUP_CYC - 1);
               brk_clr_o  = 1'b1;
               mode_ld    = 1'b1;
            end
         end
         PL_SETUP:    if (tmr_zero_i) st_d = PL_BRK_REQ;
         PL_BRK_REQ:  st_d = PL_BRK_WAIT;
         PL_BRK_WAIT: begin
            if (brk_done_i) begin
               brk_inc_o = 1'b1;
               st_d      = brk_last_i ? PL_ACTIVE : PL_BRK_REQ;
            end
         end
         PL_ACTIVE:   if (disable_req_i) st_d = PL_DRAIN;
         PL_DRAIN: begin
            if (tx_idle_i) begin
               if (mode_q == PL_MODE_RSTPIN) begin
                  st_d = PL_REL;
               end else begin
                  st_d       = PL_HOLD;
                  tmr_load_o = 1'b1;
                  tmr_val_o  = CW'(HOLD_CYC - 1);
               end
            end
         end
         PL_HOLD:     if (tmr_zero_i) st_d = PL_IDLE;
         PL_REL:      st_d = PL_IDLE;
         default:     st_d = PL_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PL_IDLE;
         mode_q <= PL_MODE_DATOVR;
      end else begin
         st_q <= st_d;
         if (mode_ld) mode_q <= pl_mode_e'(mode_i);
      end
   end

   assign state_o = st_q;
   assign mode_o  = mode_q;

   // Entry starts only from idle.
   AST_SETUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PL_SETUP && $past(st_q) != PL_SETUP) |-> $past(st_q) == PL_IDLE);   // R10
   // The captured mode is frozen outside idle.
   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) != PL_IDLE) |-> $stable(mode_q));   // R11
   // Teardown only ever begins from the active phase.
   AST_DRAIN_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == PL_DRAIN && $past(st_q) != PL_DRAIN) |-> $past(st_q) == PL_ACTIVE);   // R10

endmodule

// File: rtl/plseq_pins.sv
module plseq_pins
   import prog_link_pkg::*;
#(
   parameter bit RST_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pl_state_e  state_i,
   input  pl_mode_e   mode_i,
   output pl_pins_t   pins_o,
   output logic       rst_lvl_o,
   output logic       brk_start_o,
   output logic       ready_o,
   output logic [1:0] status_o
);

   pl_pins_t   p;
   pl_status_e st;
   logic       rst_pin;

   assign rst_pin = (mode_i == PL_MODE_RSTPIN);

   always_comb begin
      p  = '0;
      st = PL_ST_IDLE;
      unique case (state_i)
         PL_IDLE: st = PL_ST_IDLE;
         PL_SETUP: begin
            st = PL_ST_ENTER;
            if (rst_pin) begin
               p.rst_oe     = 1'b1;
               p.rst_assert = 1'b1;
            end else begin
               p.clk_oe  = 1'b1;
               p.dat_oe  = 1'b1;
               p.dat_lvl = 1'b1;
            end
         end
         PL_BRK_REQ, PL_BRK_WAIT, PL_ACTIVE: begin
            st           = (state_i == PL_ACTIVE) ? PL_ST_ACTIVE : PL_ST_ENTER;
            p.clk_oe     = 1'b1;
            p.clk_run    = 1'b1;
            p.dat_oe     = 1'b1;
            p.dat_lvl    = 1'b1;
            p.rst_oe     = rst_pin;
            p.rst_assert = rst_pin;
         end
         PL_DRAIN: begin
            st           = PL_ST_EXIT;
            p.clk_oe     = 1'b1;
            p.clk_run    = 1'b1;
            p.rx_sel     = 1'b1;
            p.rst_oe     = rst_pin;
            p.rst_assert = rst_pin;
         end
         PL_HOLD: begin
            st        = PL_ST_EXIT;
            p.clk_oe  = 1'b1;
            p.clk_lvl = 1'b1;
            p.rx_sel  = 1'b1;
         end
         PL_REL: begin
            st           = PL_ST_EXIT;
            p.rx_sel     = 1'b1;
            p.rst_oe     = 1'b1;
            p.rst_assert = 1'b1;
         end
         default: st = PL_ST_IDLE;
      endcase
   end

   generate
      if (RST_ACTIVE_LOW) begin : g_rst_low
         assign rst_lvl_o = p.rst_oe & ~p.rst_assert;
      end else begin : g_rst_high
         assign rst_lvl_o = p.rst_oe & p.rst_assert;
      end
   endgenerate

   assign pins_o      = p;
   assign brk_start_o = (state_i == PL_BRK_REQ);
   assign ready_o     = (state_i == PL_ACTIVE);
   assign status_o    = st;

   // The clock only stops after the PHY has been turned to receive.
   AST_EXIT_RX_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pins_o.clk_run) |-> $past(pins_o.rx_sel));   // R5
   // The reset pin is let go only after clock and data were already released.
   AST_RST_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pins_o.rst_oe) |-> $past(!pins_o.clk_oe && !pins_o.dat_oe));   // R7
   // The link-ready flag always comes with the active phase code.
   AST_READY_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> status_o == 2'd2);   // R8

endmodule

// File: rtl/prog_link_seq.sv
module prog_link_seq
   import prog_link_pkg::*;
#(
   parameter int unsigned CLK_HZ         = 250_000_000,
   parameter int unsigned SETUP_NS       = 90,
   parameter int unsigned HOLD_US        = 1000,
   parameter int unsigned BREAKS         = 2,
   parameter bit          RST_ACTIVE_LOW = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_i,
   input  logic       enable_req_i,
   input  logic       disable_req_i,
   output logic       phy_brk_start_o,
   input  logic       phy_brk_done_i,
   output logic       phy_rx_sel_o,
   input  logic       phy_tx_idle_i,
   output logic       phy_clk_run_o,
   output logic       clk_oe_o,
   output logic       clk_out_o,
   output logic       dat_oe_o,
   output logic       dat_out_o,
   output logic       rst_oe_o,
   output logic       rst_out_o,
   output logic       link_ready_o,
   output logic [1:0] status_o
);

   localparam longint      SETUP_L   = pl_ns_to_cyc(longint'(CLK_HZ), longint'(SETUP_NS));
   localparam longint      HOLD_L    = pl_us_to_cyc(longint'(CLK_HZ), longint'(HOLD_US));
   localparam int unsigned SETUP_CYC = (SETUP_L < 1) ? 1 : int'(SETUP_L);
   localparam int unsigned HOLD_CYC  = (HOLD_L < 1) ? 1 : int'(HOLD_L);
   localparam int unsigned MAX_CYC   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
   localparam int unsigned CW        = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (BREAKS < 1) begin : g_bad_breaks
         $fatal(1, "BREAKS must be at least one");
      end
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $fatal(1, "CLK_HZ must be at least 1 MHz");
      end
   endgenerate

   pl_state_e     state;
   pl_mode_e      mode_q;
   logic          tmr_load, tmr_zero, brk_clr, brk_inc, brk_last;
   logic [CW-1:0] tmr_val;
   pl_pins_t      pins;
   logic          rst_lvl;

   plseq_ctrl #(
      .CW        (CW),
      .SETUP_CYC (SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_i        (mode_i),
      .enable_req_i  (enable_req_i),
      .disable_req_i (disable_req_i),
      .tmr_zero_i    (tmr_zero),
      .brk_done_i    (phy_brk_done_i),
      .brk_last_i    (brk_last),
      .tx_idle_i     (phy_tx_idle_i),
      .state_o       (state),
      .mode_o        (mode_q),
      .tmr_load_o    (tmr_load),
      .tmr_val_o     (tmr_val),
      .brk_clr_o     (brk_clr),
      .brk_inc_o     (brk_inc)
   );

   plseq_timer #(.CW(CW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .zero_o     (tmr_zero)
   );

   plseq_brk_cnt #(.BREAKS(BREAKS)) u_brk (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (brk_clr),
      .inc_i  (brk_inc),
      .last_o (brk_last)
   );

   plseq_pins #(.RST_ACTIVE_LOW(RST_ACTIVE_LOW)) u_pins (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (state),
      .mode_i      (mode_q),
      .pins_o      (pins),
      .rst_lvl_o   (rst_lvl),
      .brk_start_o (phy_brk_start_o),
      .ready_o     (link_ready_o),
      .status_o    (status_o)
   );

   assign phy_rx_sel_o  = pins.rx_sel;
   assign phy_clk_run_o = pins.clk_run;
   assign clk_oe_o      = pins.clk_oe;
   assign clk_out_o     = pins.clk_lvl;
   assign dat_oe_o      = pins.dat_oe;
   assign dat_out_o     = pins.dat_lvl;
   assign rst_oe_o      = pins.rst_oe;
   assign rst_out_o     = rst_lvl;

   // Interval counters that watch the pins from outside the sequencing logic.
   logic        pre_flag, hold_flag;
   logic [31:0] pre_len, hold_len, brk_seen;

   assign pre_flag  = ((dat_oe_o && dat_out_o) || rst_oe_o) && !phy_clk_run_o;
   assign hold_flag = clk_oe_o && clk_out_o && !phy_clk_run_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_len  <= '0;
         hold_len <= '0;
         brk_seen <= '0;
      end else begin
         pre_len  <= pre_flag  ? pre_len + 1'b1  : '0;
         hold_len <= hold_flag ? hold_len + 1'b1 : '0;
         if (status_o == 2'd0)     brk_seen <= '0;
         else if (phy_brk_start_o) brk_seen <= brk_seen + 1'b1;
      end
   end

   AST_SETUP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_clk_run_o) |-> pre_len >= SETUP_CYC);   // R1
   AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_flag) |-> hold_len == HOLD_CYC);   // R6
   AST_READY_AFTER_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_ready_o) |-> brk_seen == BREAKS);   // R4
   AST_DATA_HIGH_WHEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      (phy_clk_run_o && !phy_rx_sel_o) |-> (dat_oe_o && dat_out_o));   // R3

endmodule

// File: tb/prog_link_seq_tb.sv
module prog_link_seq_tb;

   localparam int SETUP_T = (90 * 250 + 999) / 1000;   // 23 cycles of 4 ns
   localparam int HOLD_T  = 2 * 250;                   // 2 us = 500 cycles
   localparam int NBRK    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_i = 1'b0, enable_req_i = 1'b0, disable_req_i = 1'b0;
   logic phy_brk_done_i = 1'b0, phy_tx_idle_i = 1'b1;
   logic phy_brk_start_o, phy_rx_sel_o, phy_clk_run_o;
   logic clk_oe_o, clk_out_o, dat_oe_o, dat_out_o, rst_oe_o, rst_out_o, link_ready_o;
   logic [1:0] status_o;

   always #2 clk = ~clk;

   prog_link_seq #(
      .CLK_HZ(250_000_000), .SETUP_NS(90), .HOLD_US(2), .BREAKS(NBRK), .RST_ACTIVE_LOW(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .enable_req_i(enable_req_i),
      .disable_req_i(disable_req_i), .phy_brk_start_o(phy_brk_start_o),
      .phy_brk_done_i(phy_brk_done_i), .phy_rx_sel_o(phy_rx_sel_o),
      .phy_tx_idle_i(phy_tx_idle_i), .phy_clk_run_o(phy_clk_run_o),
      .clk_oe_o(clk_oe_o), .clk_out_o(clk_out_o), .dat_oe_o(dat_oe_o),
      .dat_out_o(dat_out_o), .rst_oe_o(rst_oe_o), .rst_out_o(rst_out_o),
      .link_ready_o(link_ready_o), .status_o(status_o)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // Behavioural model: phase names as integers, plain counters.
   // 0 idle, 1 guard, 2 break request, 3 break wait, 4 up, 5 drain, 6 park, 7 release
   int m_ph = 0;
   int m_mode = 0;
   int m_cnt = 0;
   int m_brk = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_mode = 0; m_cnt = 0; m_brk = 0;
      end else begin
         case (m_ph)
            0: if (enable_req_i) begin m_ph = 1; m_mode = int'(mode_i); m_cnt = 0; m_brk = 0; end
            1: begin m_cnt++; if (m_cnt == SETUP_T) m_ph = 2; end
            2: m_ph = 3;
            3: if (phy_brk_done_i) begin m_brk++; m_ph = (m_brk == NBRK) ? 4 : 2; end
            4: if (disable_req_i) m_ph = 5;
            5: if (phy_tx_idle_i) begin m_ph = (m_mode == 1) ? 7 : 6; m_cnt = 0; end
            6: begin m_cnt++; if (m_cnt == HOLD_T) m_ph = 0; end
            default: m_ph = 0;
         endcase
      end
   end

   // Expected {clk_oe,clk_out,run,dat_oe,dat_out,rst_oe,rst_out,rx_sel,brk_start,ready}
   function automatic logic [9:0] exp_pins(int ph, int md);
      case (ph)
         1: return (md == 1) ? 10'b0000010000 : 10'b1001100000;
         2: return (md == 1) ? 10'b1011110010 - 10'b0000000000 + 10'b0 : 10'b1011100010;
         3: return (md == 1) ? 10'b1011110000 : 10'b1011100000;
         4: return (md == 1) ? 10'b1011110001 : 10'b1011100001;
         5: return (md == 1) ? 10'b1010010100 : 10'b1010000100;
         6: return 10'b1100000100;
         7: return 10'b0000010100;
         default: return 10'b0;
      endcase
   endfunction

   function automatic logic [1:0] exp_status(int ph);
      case (ph)
         0: return 2'd0;
         1, 2, 3: return 2'd1;
         4: return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic string tag_of(int ph, int md);
      case (ph)
         0: return "R9";
         1: return (md == 1) ? "R2" : "R1";
         2, 3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         default: return "R7";
      endcase
   endfunction

   // Per-cycle comparison on the falling edge.
   always @(negedge clk) begin
      logic [9:0] act_p, exp_p;
      act_p = {clk_oe_o, clk_out_o, phy_clk_run_o, dat_oe_o, dat_out_o,
               rst_oe_o, rst_out_o, phy_rx_sel_o, phy_brk_start_o, link_ready_o};
      exp_p = exp_pins(m_ph, m_mode);
      if (!finished) begin
         checks++;
         if (act_p !== exp_p) begin
            failures++;
            $display("FAIL %s pins at cycle %0d: actual %b expected %b",
                     tag_of(m_ph, m_mode), cyc, act_p, exp_p);
         end
         checks++;
         if (status_o !== exp_status(m_ph)) begin   // R8
            failures++;
            $display("FAIL R8 status at cycle %0d: actual %0d expected %0d",
                     cyc, status_o, exp_status(m_ph));
         end
      end
   end

   // Stand-in PHY: answers a break request six cycles later.
   int bdelay = 0;
   always @(negedge clk) begin
      phy_brk_done_i <= 1'b0;
      if (bdelay > 0) begin
         bdelay--;
         if (bdelay == 0) phy_brk_done_i <= 1'b1;
      end
      if (phy_brk_start_o) bdelay = 6;
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s directed: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_status(input logic [1:0] v, input string tag);
      int k;
      k = 0;
      while (status_o !== v && k < 3000) begin @(negedge clk); k++; end
      chk({30'd0, status_o}, {30'd0, v}, tag);
   endtask

   task automatic pulse_en();
      enable_req_i = 1'b1; @(negedge clk); enable_req_i = 1'b0;
   endtask

   task automatic pulse_dis();
      disable_req_i = 1'b1; @(negedge clk); disable_req_i = 1'b0;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 60000 && !finished) begin
         failures++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
      end
   end

   initial begin
      tick(3);
      // R9: reset state, everything released
      chk({22'd0, clk_oe_o, dat_oe_o, rst_oe_o, rst_out_o, phy_clk_run_o,
           phy_rx_sel_o, link_ready_o, phy_brk_start_o, status_o}, 32'd0, "R9");
      rst_n = 1'b1;
      tick(2);

      // Mode 0 entry
      mode_i = 1'b0;
      pulse_en();
      tick(4);
      // R10: enable and disable while entering have no effect; R11: mode change ignored
      mode_i = 1'b1;
      enable_req_i = 1'b1; disable_req_i = 1'b1;
      tick(1);
      enable_req_i = 1'b0; disable_req_i = 1'b0;
      chk({31'd0, rst_oe_o}, 32'd0, "R11");
      chk({30'd0, status_o}, 32'd1, "R10");
      wait_status(2'd2, "R4");
      chk({31'd0, link_ready_o}, 32'd1, "R4");
      tick(5);
      // R10: enable while active has no effect
      pulse_en();
      tick(2);
      chk({30'd0, status_o}, 32'd2, "R10");
      chk({31'd0, rst_oe_o}, 32'd0, "R11");

      // Mode 0 exit with the PHY busy for a while
      phy_tx_idle_i = 1'b0;
      pulse_dis();
      tick(6);
      chk({30'd0, phy_rx_sel_o, phy_clk_run_o}, 32'd3, "R5");
      phy_tx_idle_i = 1'b1;
      tick(3);
      chk({30'd0, clk_oe_o, clk_out_o}, 32'd3, "R6");
      wait_status(2'd0, "R6");
      chk({29'd0, clk_oe_o, dat_oe_o, rst_oe_o}, 32'd0, "R6");
      // R10: disable while idle has no effect
      pulse_dis();
      tick(2);
      chk({30'd0, status_o}, 32'd0, "R10");

      // Mode 1 entry, mode flipped back mid-sequence
      mode_i = 1'b1;
      pulse_en();
      chk({30'd0, rst_oe_o, rst_out_o}, 32'd2, "R2");
      mode_i = 1'b0;
      tick(3);
      chk({30'd0, clk_oe_o, dat_oe_o}, 32'd0, "R2");
      wait_status(2'd2, "R4");
      chk({30'd0, rst_oe_o, rst_out_o}, 32'd2, "R11");
      tick(4);

      // Mode 1 exit, PHY already idle
      pulse_dis();
      tick(1);
      chk({29'd0, clk_oe_o, dat_oe_o, rst_oe_o}, 32'd1, "R7");
      wait_status(2'd0, "R7");
      chk({31'd0, rst_oe_o}, 32'd0, "R7");

      // Back-to-back mode 0 cycle with no PHY stall
      mode_i = 1'b0;
      pulse_en();
      wait_status(2'd2, "R3");
      pulse_dis();
      wait_status(2'd0, "R6");
      tick(4);
      summary();
   end

endmodule